// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a synchronous RAM of 32-bit words. Every address, control and write-data input is captured on the rising clock edge, and read data leave through an output register. A read issued in one cycle therefore shows its word after the second rising edge. The word address is the captured upper address bits with a captured 2-bit low field appended, which lets an outside burst sequencer walk through four consecutive words.

Writes are steered per 8-bit lane. A byte-write enable combines with four lane selects. A global write enable takes priority over both and stores the whole word. Three chip selects, two active low and one active high, must all be active for a cycle to take effect. The data path uses separate input and output buses, so no tri-state bus is needed. An output-valid flag replaces bus drive and is gated at once by an asynchronous output enable. The flag is also held off for the first read that comes right after a deselected cycle, so two banks sharing a bus never both present data.

Top module: `pipe_sram`

## Requirements
- R1: While reset is asserted and after it is released, with no read completed, `rvalid` is 0 and `rdata` is 0.
- R2: A selected read cycle whose inputs are sampled at rising edge k presents the stored word on `rdata`, with `rvalid` = 1, after rising edge k+1.
- R3: The word address is `{addr_hi, burst_lo}`, with `burst_lo` as the two least significant bits. The four words that share `addr_hi` are distinct locations.
- R4: With `glob_wr_n`=1, `byte_en_n`=0 and `lane_sel_n[i]`=0, lane i (bits 8i+7:8i) takes `wdata` bits 8i+7:8i. Lanes whose select is 1 keep their old contents.
- R5: With `glob_wr_n`=0, all four lanes are written whatever the values of `byte_en_n` and `lane_sel_n`.
- R6: With `glob_wr_n`=1 and `byte_en_n`=1, the cycle is a read, and `lane_sel_n` has no effect on memory.
- R7: A cycle is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A deselected cycle writes nothing, and its result slot has `rvalid`=0.
- R8: `oe_n` acts without a clock. While `oe_n`=1, `rvalid` is 0 and `rdata` is 0 in the same cycle. Whenever `rvalid` is 0, `rdata` is 0.
- R9: A read whose cycle directly follows a deselected cycle, or follows reset, gives `rvalid`=0 whatever `oe_n` is. A read directly after a selected cycle is not masked.
- R10: A selected write cycle gives `rvalid`=0 in its result slot, and the output data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | $clog2(DEPTH)-2 | Upper word-address bits |
| burst_lo | input | 2 | Low two word-address bits |
| wdata | input | 32 | Write data |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| glob_wr_n | input | 1 | Whole-word write, active low |
| byte_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
Each operation is driven on a falling edge and sampled at the next rising edge. Its result is due two falling edges later, after the output register loads on the following rising edge. The bench keeps a two-slot queue of expected results and compares the oldest entry at each falling edge. Write effects enter the reference memory when the operation is issued, so a read that comes later always sees them. The output-enable gating has no latency: the bench computes it from the `oe_n` level at compare time and also probes it between clock edges.

// File: rtl/sram_pkg.sv
package sram_pkg;
  parameter int LANE_W = 8;

  function automatic int lane_count(input int dw);
    return dw / LANE_W;
  endfunction
endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
  import sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-3:0]    addr_hi,
  input  logic [1:0]       burst_lo,
  input  logic [DW-1:0]    wdata,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             glob_wr_n,
  input  logic             byte_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic             sel_q,
  output logic             sel_d,
  output logic [LANES-1:0] lane_we
);
  logic [AW-1:0]    addr_r,  addr_nx;
  logic [DW-1:0]    wdat_r,  wdat_nx;
  logic             sel_r,   sel_nx;
  logic             seld_r,  seld_nx;
  logic             glob_r,  glob_nx;
  logic             bwe_r,   bwe_nx;
  logic [LANES-1:0] lsel_r,  lsel_nx;

  always_comb begin
    addr_nx = {addr_hi, burst_lo};
    wdat_nx = wdata;
    sel_nx  = ~cs1_n & cs2 & ~cs3_n;
    seld_nx = sel_r;
    glob_nx = glob_wr_n;
    bwe_nx  = byte_en_n;
    lsel_nx = lane_sel_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r <= '0;
      wdat_r <= '0;
      sel_r  <= 1'b0;
      seld_r <= 1'b0;
      glob_r <= 1'b1;
      bwe_r  <= 1'b1;
      lsel_r <= '1;
    end else begin
      addr_r <= addr_nx;
      wdat_r <= wdat_nx;
      sel_r  <= sel_nx;
      seld_r <= seld_nx;
      glob_r <= glob_nx;
      bwe_r  <= bwe_nx;
      lsel_r <= lsel_nx;
    end
  end

  always_comb begin
    if (!glob_r) lane_we = '1;
    else         lane_we = {LANES{~bwe_r}} & ~lsel_r;
  end

  assign addr_q  = addr_r;
  assign wdata_q = wdat_r;
  assign sel_q   = sel_r;
  assign sel_d   = seld_r;
endmodule

// File: rtl/sram_array.sv
module sram_array
  import sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             sel,
  input  logic [LANES-1:0] lane_we,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              wr_en;

    assign wr_en = sel & lane_we[g];

    always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          first_rd,
  input  logic [DW-1:0] mem_rdata,
  input  logic          oe_n,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] dout_r, dout_nx;
  logic          rdv_r,  rdv_nx;
  logic          mask_r, mask_nx;

  always_comb begin
    dout_nx = dout_r;
    if (rd_en) dout_nx = mem_rdata;
    rdv_nx  = rd_en;
    mask_nx = first_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_r <= '0;
      rdv_r  <= 1'b0;
      mask_r <= 1'b1;
    end else begin
      dout_r <= dout_nx;
      rdv_r  <= rdv_nx;
      mask_r <= mask_nx;
    end
  end

  assign rvalid = rdv_r & ~oe_n & ~mask_r;
  assign rdata  = rvalid ? dout_r : '0;

  p_mask_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && first_rd) |=> !rvalid);

  p_write_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  p_hold_dout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout_r));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import sram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LANES = DW / LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-3:0]    addr_hi,
  input  logic [1:0]       burst_lo,
  input  logic [DW-1:0]    wdata,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             glob_wr_n,
  input  logic             byte_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic             sel_q;
  logic             sel_d;
  logic [LANES-1:0] lane_we;
  logic [DW-1:0]    mem_rdata;
  logic             rd_en;

  sram_in_stage #(.AW(AW), .DW(DW), .LANES(LANES)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_hi    (addr_hi),
    .burst_lo   (burst_lo),
    .wdata      (wdata),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .glob_wr_n  (glob_wr_n),
    .byte_en_n  (byte_en_n),
    .lane_sel_n (lane_sel_n),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .sel_q      (sel_q),
    .sel_d      (sel_d),
    .lane_we    (lane_we)
  );

  sram_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .LANES(LANES)) u_mem (
    .clk     (clk),
    .addr    (addr_q),
    .wdata   (wdata_q),
    .sel     (sel_q),
    .lane_we (lane_we),
    .rdata   (mem_rdata)
  );

  assign rd_en = sel_q & ~(|lane_we);

  sram_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .first_rd  (~sel_d),
    .mem_rdata (mem_rdata),
    .oe_n      (oe_n),
    .rvalid    (rvalid),
    .rdata     (rdata)
  );

  p_glob_all_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_wr_n |=> (&lane_we));

  p_desel_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs1_n || !cs2 || cs3_n) |=> !rd_en);
endmodule

// File: tb/pipe_sram_bench.sv
`timescale 1ns/1ps
module pipe_sram_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-3:0] addr_hi;
  logic [1:0]    burst_lo;
  logic [31:0]   wdata;
  logic          cs1_n, cs2, cs3_n;
  logic          glob_wr_n, byte_en_n;
  logic [3:0]    lane_sel_n;
  logic          oe_n;
  logic [31:0]   rdata;
  logic          rvalid;

  int tests = 0;
  int fails = 0;

  logic [31:0] model [DEPTH];
  logic        prev_sel = 1'b0;
  logic        q0_live = 1'b0, q1_live = 1'b0;
  logic        q0_rd, q1_rd;
  logic [31:0] q0_d, q1_d;
  string       q0_tag, q1_tag;

  always #2.5 clk = ~clk;

  pipe_sram #(.DEPTH(DEPTH)) u_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .burst_lo(burst_lo),
    .wdata(wdata), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .glob_wr_n(glob_wr_n), .byte_en_n(byte_en_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [3:0] lanes_of(input logic g_n, input logic be_n,
                                          input logic [3:0] ls_n);
    if (!g_n) return 4'hF;
    if (!be_n) return ~ls_n;
    return 4'h0;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] ln);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (ln[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic ev, input logic [31:0] ed);
    tests++;
    if (rvalid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  // one operation per clock: drive at falling edge, result compared two falling edges later
  task automatic step(input logic [AW-1:0] a, input logic [31:0] d, input logic [2:0] cs,
                      input logic g_n, input logic be_n, input logic [3:0] ls_n,
                      input logic oe, input string tag);
    logic sel;
    logic [3:0] ln;
    logic ev;
    @(negedge clk);
    if (q1_live) begin
      ev = q1_rd & ~oe_n;
      chk(q1_tag, ev, ev ? q1_d : 32'h0);
    end
    q1_live = q0_live; q1_rd = q0_rd; q1_d = q0_d; q1_tag = q0_tag;
    addr_hi = a[AW-1:2]; burst_lo = a[1:0]; wdata = d;
    {cs1_n, cs2, cs3_n} = cs;
    glob_wr_n = g_n; byte_en_n = be_n; lane_sel_n = ls_n; oe_n = oe;
    sel = (cs == 3'b010);
    ln  = lanes_of(g_n, be_n, ls_n);
    q0_live = 1'b1;
    q0_rd   = sel & (ln == 4'h0) & prev_sel;
    q0_d    = model[a];
    q0_tag  = tag;
    if (sel && ln != 4'h0) model[a] = merge(model[a], d, ln);
    prev_sel = sel;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(a, 32'h0, 3'b010, 1'b1, 1'b1, 4'hF, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step('0, 32'h0, 3'b110, 1'b1, 1'b1, 4'hF, 1'b0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 1'b0;
    addr_hi = '0; burst_lo = '0; wdata = '0;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
    glob_wr_n = 1'b1; byte_en_n = 1'b1; lane_sel_n = 4'hF; oe_n = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 1'b0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", 1'b0, 32'h0);

    // first read right after reset is masked
    rd(8'd0, "R9");
    // fill every word with a full write
    for (int i = 0; i < DEPTH; i++)
      step(i[AW-1:0], 32'hA5000000 ^ (i * 32'h01010101), 3'b010, 1'b0, 1'b1, 4'hF, 1'b0, "R5");

    rd(8'd5, "R2");
    rd(8'd9, "R2");
    step(8'd5, 32'h11223344, 3'b010, 1'b1, 1'b0, 4'b1101, 1'b0, "R10");
    rd(8'd5, "R4");
    step(8'd5, 32'hCAFEF00D, 3'b010, 1'b1, 1'b0, 4'b0110, 1'b0, "R10");
    rd(8'd5, "R4");
    step(8'd6, 32'hDEADBEEF, 3'b010, 1'b0, 1'b1, 4'hF, 1'b0, "R5");
    step(8'd7, 32'h0BADC0DE, 3'b010, 1'b0, 1'b0, 4'b1110, 1'b0, "R5");
    rd(8'd6, "R5");
    rd(8'd7, "R5");
    step(8'd6, 32'h12345678, 3'b010, 1'b1, 1'b1, 4'h0, 1'b0, "R6");
    rd(8'd6, "R6");
    // deselected writes: each chip select alone
    step(8'd8, 32'h55555555, 3'b110, 1'b0, 1'b1, 4'hF, 1'b0, "R7");
    step(8'd8, 32'h66666666, 3'b000, 1'b0, 1'b1, 4'hF, 1'b0, "R7");
    step(8'd8, 32'h77777777, 3'b011, 1'b0, 1'b1, 4'hF, 1'b0, "R7");
    rd(8'd8, "R9");
    rd(8'd8, "R7");
    idle("R7");
    rd(8'd9, "R9");
    rd(8'd9, "R9");
    // four words sharing one upper address
    for (int j = 0; j < 4; j++)
      step({6'd3, j[1:0]}, 32'h30303030 + j, 3'b010, 1'b0, 1'b1, 4'hF, 1'b0, "R3");
    rd({6'd3, 2'd3}, "R3");
    rd({6'd3, 2'd0}, "R3");
    rd({6'd3, 2'd2}, "R3");
    rd({6'd3, 2'd1}, "R3");
    // output enable high on a read slot, then asynchronous probe
    step(8'd12, 32'h0, 3'b010, 1'b1, 1'b1, 4'hF, 1'b1, "R8");
    rd(8'd13, "R8");
    rd(8'd14, "R8");
    rd(8'd15, "R8");
    begin
      logic sv;
      sv = oe_n;
      oe_n = 1'b1;
      #0.5;
      chk("R8", 1'b0, 32'h0);
      oe_n = sv;
      #0.5;
    end

    // constrained random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] cs;
      logic g_n, be_n, oe;
      int unsigned r;
      r    = $urandom % 10;
      cs   = (r < 8) ? 3'b010 : 3'($urandom % 8);
      g_n  = ($urandom % 6) != 0;
      be_n = ($urandom % 3) != 0;
      oe   = ($urandom % 8) == 0;
      step(AW'($urandom % DEPTH), $urandom, cs, g_n, be_n, 4'($urandom),
           oe, "R2");
    end
    idle("R7");
    idle("R7");
    idle("R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule